// File: doc/BRIEF.md
# Multi-Port Cell Receive Master

This block is the cell-layer end of a shared receive bus with several PHY ports. Every port has its own cell-available line, and the master watches all of them on every clock. There is no null address. When the master has no port selected, the address lines carry no meaning. To take a cell, the master drives a port's address and then pulls an active-low enable. It then counts the 52 bytes of that cell as they arrive, with a fixed two-clock lag after enable. Each cell goes out on a byte stream that has valid, first and last markers and a source-port tag.

At each cell boundary the master makes one decision. If some other port is requesting, it switches to the next such port in round-robin order, which costs one cycle with enable high. If only the current port still has a cell, it keeps enable low, so the next cell follows with no gap. If no port is requesting, it lets the bus go idle. A cell whose first byte lacks the start-of-cell flag is dropped and reported, and the capture side then hunts for the next flag. The downstream ready input is looked at only at cell boundaries. The downstream must accept bytes for as long as a cell is running.

Top module: `rxm_cell_rx_master`

## Requirements
- R1: After reset, enable_n is 1, out_valid is 0 and soc_err is 0.
- R2: From idle, when a port's cell_avail is sampled high at edge S and out_ready is 1, port_addr carries that port's index (0 to NPORTS-1) after S. enable_n goes to 0 after S+1, and the first byte of the cell appears on the output after S+3.
- R3: port_addr changes only in a cycle where enable_n is 1. Once enable_n is 0, the address stays fixed until the cell ends.
- R4: Every delivered cell has exactly 52 consecutive out_valid bytes. out_first is set on byte 0 only, out_last on byte 51 only, and out_port gives the port the cell came from.
- R5: If at a cell's end the current port still shows a cell and no other port does, enable_n stays 0. The next cell's first byte then appears exactly 52 cycles after the previous first byte.
- R6: If at a cell's end another port shows a cell, the master raises enable_n for exactly one cycle with the new address. The new cell's first byte appears 53 cycles after the previous first byte.
- R7: When several ports request, the grant goes to the first requesting port after the last-served port, searching in increasing index order and wrapping around.
- R8: If out_ready is 0 at a selection point, enable_n stays 1 and no cell is started until out_ready returns to 1.
- R9: If the first byte of a cell lacks the start-of-cell flag, soc_err pulses for one cycle. No byte of that cell is delivered, and delivery resumes at the next byte that carries the flag.
- R10: When no port requests at a cell's end, enable_n returns to 1 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cell_avail | input | NPORTS | One cell-available line per PHY port |
| port_addr | output | clog2(NPORTS) | Index of the selected port |
| enable_n | output | 1 | Active-low read enable to the selected port |
| rx_data | input | DW | Byte from the selected port |
| rx_soc | input | 1 | Start-of-cell flag, set with the first byte |
| out_ready | input | 1 | Downstream ready, sampled at cell boundaries |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DW | Output byte |
| out_first | output | 1 | Marks byte 0 of a cell |
| out_last | output | 1 | Marks the last byte of a cell |
| out_port | output | clog2(NPORTS) | Source port of the current byte |
| soc_err | output | 1 | One-cycle pulse on a missing start-of-cell |

## Verification
The assertions check four things on every cycle. The address moves only while enable is high. An arbiter grant always falls on a requesting port. A last byte is followed either by silence or by a new first byte, and bytes inside a cell are contiguous. An error pulse never lasts longer than one cycle. The bench scenarios are needed for the rest. Only they can show the exact latency from request to first byte, and the 52 and 53 cycle spacings for continuation and switching. They also show the round-robin order across several cells, that backpressure holds off enable, and that a corrupted cell is dropped while its successor is delivered.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_XFER = 2'd2
   } rxm_state_e;
endpackage

// File: rtl/rxm_rr_arb.sv
module rxm_rr_arb #(
   parameter int N  = 4,
   localparam int PW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic [PW-1:0] last,
   output logic [PW-1:0] gnt,
   output logic          any
);
   always_comb begin
      gnt = last;
      any = 1'b0;
      for (int k = 1; k <= N; k++) begin
         if (!any && req[(int'(last) + k) % N]) begin
            gnt = PW'((int'(last) + k) % N);
            any = 1'b1;
         end
      end
   end

   // R7
   grant_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[gnt]);
endmodule

// File: rtl/rxm_capture.sv
module rxm_capture #(
   parameter int DW   = 8,
   parameter int N    = 4,
   parameter int CELL = 52,
   localparam int PW  = $clog2(N),
   localparam int BW  = $clog2(CELL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [PW-1:0] take_port,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_soc,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_first,
   output logic          out_last,
   output logic [PW-1:0] out_port,
   output logic          soc_err
);
   localparam logic [BW-1:0] LAST_IDX = BW'(CELL - 1);

   logic [BW-1:0] bidx;
   logic          hunt;
   logic          emit;

   assign emit = take && ((bidx != '0) || rx_soc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bidx      <= '0;
         hunt      <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_first <= 1'b0;
         out_last  <= 1'b0;
         out_port  <= '0;
         soc_err   <= 1'b0;
      end else begin
         out_valid <= emit;
         soc_err   <= 1'b0;
         if (emit) begin
            out_data  <= rx_data;
            out_first <= (bidx == '0);
            out_last  <= (bidx == LAST_IDX);
            out_port  <= take_port;
            bidx      <= (bidx == LAST_IDX) ? '0 : bidx + 1'b1;
            hunt      <= 1'b0;
         end else if (take && !hunt) begin
            soc_err <= 1'b1;
            hunt    <= 1'b1;
         end
      end
   end

   // R9
   err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soc_err |=> !soc_err);
   // R4
   last_then_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |=> (!out_valid || out_first));
   // R4
   cell_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_first) |-> $past(out_valid));
endmodule

// File: rtl/rxm_cell_rx_master.sv
module rxm_cell_rx_master
   import rxm_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int DW     = 8,
   parameter int CELL   = 52,
   localparam int PW    = $clog2(NPORTS),
   localparam int CW    = $clog2(CELL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] cell_avail,
   output logic [PW-1:0]     port_addr,
   output logic              enable_n,
   input  logic [DW-1:0]     rx_data,
   input  logic              rx_soc,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DW-1:0]     out_data,
   output logic              out_first,
   output logic              out_last,
   output logic [PW-1:0]     out_port,
   output logic              soc_err
);
   generate
      if (NPORTS < 2) begin : g_bad_ports
         $error("NPORTS must be at least 2");
      end
      if (CELL < 2) begin : g_bad_cell
         $error("CELL must be at least 2");
      end
   endgenerate

   localparam logic [CW-1:0] CELL_CNT = CW'(CELL);

   rxm_state_e        state;
   logic [PW-1:0]     cur;
   logic [CW-1:0]     ecnt;
   logic [NPORTS-1:0] req;
   logic [PW-1:0]     gnt;
   logic              any;
   logic              take;
   logic [PW-1:0]     take_port;

   always_comb begin
      req = cell_avail;
      if (state != ST_IDLE) req[cur] = 1'b0;
   end

   rxm_rr_arb #(.N(NPORTS)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req),
      .last (cur),
      .gnt  (gnt),
      .any  (any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur      <= PW'(NPORTS - 1);
         ecnt     <= '0;
         enable_n <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (any && out_ready) begin
                  cur   <= gnt;
                  state <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               enable_n <= 1'b0;
               ecnt     <= CW'(1);
               state    <= ST_XFER;
            end
            default: begin
               if (ecnt != CELL_CNT) begin
                  ecnt <= ecnt + 1'b1;
               end else if (!out_ready) begin
                  enable_n <= 1'b1;
                  state    <= ST_IDLE;
               end else if (any) begin
                  cur      <= gnt;
                  enable_n <= 1'b1;
                  state    <= ST_ADDR;
               end else if (cell_avail[cur]) begin
                  ecnt <= CW'(1);
               end else begin
                  enable_n <= 1'b1;
                  state    <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign port_addr = cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take      <= 1'b0;
         take_port <= '0;
      end else begin
         take      <= !enable_n;
         take_port <= cur;
      end
   end

   rxm_capture #(.DW(DW), .N(NPORTS), .CELL(CELL)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .take_port(take_port),
      .rx_data  (rx_data),
      .rx_soc   (rx_soc),
      .out_valid(out_valid),
      .out_data (out_data),
      .out_first(out_first),
      .out_last (out_last),
      .out_port (out_port),
      .soc_err  (soc_err)
   );

   // R3
   addr_moves_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_addr) |-> enable_n);
   // R3
   enable_fall_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(enable_n) |-> $stable(port_addr));
endmodule

// File: tb/rxm_cell_rx_master_test.sv
module rxm_cell_rx_master_test;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] cell_avail;
   logic [1:0]   port_addr;
   logic         enable_n;
   logic [7:0]   rx_data = '0;
   logic         rx_soc = 1'b0;
   logic         out_ready = 1'b1;
   logic         out_valid;
   logic [7:0]   out_data;
   logic         out_first;
   logic         out_last;
   logic [1:0]   out_port;
   logic         soc_err;

   always #2.5 clk = ~clk;

   rxm_cell_rx_master uut (
      .clk(clk), .rst_n(rst_n), .cell_avail(cell_avail), .port_addr(port_addr),
      .enable_n(enable_n), .rx_data(rx_data), .rx_soc(rx_soc), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
      .out_last(out_last), .out_port(out_port), .soc_err(soc_err)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // PHY model: cells offered per port (written by tasks) and taken (written here)
   int added [N];
   int taken [N];
   int total_taken = 0;
   int bad_cell = -1;
   int phy_idx = 0;
   logic phy_bad = 1'b0;

   initial for (int p = 0; p < N; p++) added[p] = 0;

   always_comb for (int p = 0; p < N; p++) cell_avail[p] = added[p] > taken[p];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < N; p++) taken[p] <= 0;
         phy_idx <= 0;
         rx_soc  <= 1'b0;
      end else begin
         cyc <= cyc + 1;
         if (!enable_n) begin
            rx_data <= {port_addr, 6'(phy_idx)};
            if (phy_idx == 0) begin
               taken[port_addr] <= taken[port_addr] + 1;
               total_taken      <= total_taken + 1;
               phy_bad          <= (total_taken == bad_cell);
               rx_soc           <= (total_taken != bad_cell);
            end else begin
               rx_soc <= 1'b0;
            end
            phy_idx <= (phy_idx == 51) ? 0 : phy_idx + 1;
         end else begin
            rx_soc  <= 1'b0;
            rx_data <= 8'hxx;
         end
      end
   end

   // Output monitor
   int   mon_idx = 0;
   int   mon_bad = 0;
   int   ncells = 0;
   int   err_cnt = 0;
   int   addr_viol = 0;
   int   log_port [64];
   int   log_cyc  [64];
   logic [1:0] prev_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (port_addr != prev_addr && !enable_n) addr_viol++;
         prev_addr = port_addr;
         if (soc_err) err_cnt++;
         if (out_valid) begin
            if (out_first !== (mon_idx == 0) || out_last !== (mon_idx == 51) ||
                out_data !== {out_port, 6'(mon_idx)}) begin
               mon_bad++;
               $display("FAIL R4 byte %0d: data=%h first=%b last=%b expected data=%h",
                        mon_idx, out_data, out_first, out_last, {out_port, 6'(mon_idx)});
            end
            if (mon_idx == 0) begin
               if (ncells < 64) begin
                  log_port[ncells] = int'(out_port);
                  log_cyc[ncells]  = cyc;
               end
               ncells++;
            end
            mon_idx = (mon_idx == 51) ? 0 : mon_idx + 1;
         end else if (mon_idx != 0) begin
            mon_bad++;
            $display("FAIL R4 gap inside cell at byte %0d, expected 52 contiguous bytes", mon_idx);
            mon_idx = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cells(input int n);
      for (int i = 0; i < 3000 && ncells < n; i++) @(negedge clk);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (enable_n && !out_valid) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      check(enable_n === 1'b1, "R1 enable_n", int'(enable_n), 1);
      check(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
      check(soc_err === 1'b0, "R1 soc_err", int'(soc_err), 0);
   endtask

   task automatic t_single();
      int c0 = ncells;
      int t0;
      added[1] = added[1] + 1;
      t0 = cyc;
      @(negedge clk);
      check(port_addr == 2'd1 && enable_n, "R2 addr before enable", int'(port_addr), 1);
      @(negedge clk);
      check(enable_n == 1'b0, "R2 enable low", int'(enable_n), 0);
      wait_cells(c0 + 1);
      check(ncells == c0 + 1, "R4 one cell", ncells - c0, 1);
      check(log_port[c0] == 1, "R4 port tag", log_port[c0], 1);
      check(log_cyc[c0] - t0 == 4, "R2 first byte latency", log_cyc[c0] - t0, 4);
      check(enable_n == 1'b1, "R10 idle after cell", int'(enable_n), 1);
   endtask

   task automatic t_back_to_back();
      int c0 = ncells;
      added[2] = added[2] + 2;
      wait_cells(c0 + 2);
      check(ncells == c0 + 2, "R5 two cells", ncells - c0, 2);
      check(log_cyc[c0+1] - log_cyc[c0] == 52, "R5 no gap", log_cyc[c0+1] - log_cyc[c0], 52);
      check(log_port[c0+1] == 2, "R5 same port", log_port[c0+1], 2);
   endtask

   task automatic t_round_robin();
      int c0 = ncells;
      added[0] = added[0] + 1;
      added[3] = added[3] + 1;
      wait_cells(c0 + 2);
      check(log_port[c0] == 3, "R7 first after last served", log_port[c0], 3);
      check(log_port[c0+1] == 0, "R7 wrap", log_port[c0+1], 0);
      check(log_cyc[c0+1] - log_cyc[c0] == 53, "R6 switch gap", log_cyc[c0+1] - log_cyc[c0], 53);
   endtask

   task automatic t_mid_switch();
      int c0 = ncells;
      added[1] = added[1] + 2;
      repeat (15) @(negedge clk);
      added[3] = added[3] + 1;
      wait_cells(c0 + 3);
      check(log_port[c0] == 1 && log_port[c0+1] == 3 && log_port[c0+2] == 1,
            "R6 order 1,3,1", log_port[c0+1], 3);
      check(log_cyc[c0+1] - log_cyc[c0] == 53, "R6 cell not interrupted",
            log_cyc[c0+1] - log_cyc[c0], 53);
   endtask

   task automatic t_backpressure();
      int c0 = ncells;
      int low = 0;
      out_ready = 1'b0;
      added[2] = added[2] + 1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!enable_n) low++;
      end
      check(low == 0, "R8 enable held off", low, 0);
      check(ncells == c0, "R8 no cell", ncells - c0, 0);
      out_ready = 1'b1;
      wait_cells(c0 + 1);
      check(ncells == c0 + 1 && log_port[c0] == 2, "R8 resumes", ncells - c0, 1);
   endtask

   task automatic t_missing_soc();
      int c0 = ncells;
      int e0 = err_cnt;
      bad_cell = total_taken;
      added[0] = added[0] + 2;
      wait_cells(c0 + 1);
      repeat (60) @(negedge clk);
      check(err_cnt - e0 == 1, "R9 error pulse", err_cnt - e0, 1);
      check(ncells - c0 == 1, "R9 bad cell dropped", ncells - c0, 1);
      check(log_port[c0] == 0, "R9 resync port", log_port[c0], 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single();
      t_back_to_back();
      t_round_robin();
      t_mid_switch();
      t_backpressure();
      t_missing_soc();
      check(mon_bad == 0, "R4 byte stream", mon_bad, 0);
      check(addr_viol == 0, "R3 address stable while enabled", addr_viol, 0);
      check(enable_n == 1'b1, "R10 final idle", int'(enable_n), 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule